// File: doc/BRIEF.md
# Downstream Port Attach and Speed Negotiator

This block runs one downstream port of a host or hub through device attach, bus reset and speed selection. It works on the decoded line levels of the two data wires and on a one-microsecond tick. Every decision is taken only on clock edges where the tick is high. When one data line idles high long enough, the block decides that a device is attached. It sorts the device into one of two classes from which wire carries the pull-up. It then drives a single-ended-zero reset for a fixed number of ticks.

During that reset a device able to run faster may answer with a long K. The block measures how long the K lasts. If the K is long enough and space remains in the reset window, the block replies with alternating K and J chirps. It stops the chirps a margin before the reset ends. After reset it releases the wires and reads the line once. From that reading it reports low, full or high speed. It then watches for the line condition that means the device has left.

The output drivers and termination are outside the block. They are controlled through a drive-enable and two drive-value outputs.

Top module: `usbn_port_negotiator`

## Requirements
- R1: After reset the block does not drive the wires (`drv_en_o`=0, `drv_dp_o`=0, `drv_dm_o`=0), and `speed_o` reads 0. Speed codes are: 0 no device, 1 low, 2 full, 3 high.
- R2: An attach is accepted after `DEBOUNCE_TICKS` consecutive ticks of one idle level. The idle levels are J (dp=1, dm=0) and low-speed idle (dp=0, dm=1). Any other level in between restarts the count. On the edge of the last of these ticks the block starts driving SE0 (`drv_en_o`=1, dp=0, dm=0).
- R3: An attach that idles with dm high is a low-speed device. During its reset the block never chirps, even when the line shows K. After reset it reports speed 1.
- R4: The bus reset lasts exactly `RESET_TICKS` ticks from its start. After that the drive is released, and no port with a reported speed is ever driven.
- R5: A device chirp is valid only if the line shows K (dp=0, dm=1) for at least `CHIRP_MIN_TICKS` consecutive ticks and then SE0. A shorter K is ignored and the block keeps driving SE0.
- R6: A full-capable attach that shows no valid chirp during reset is reported as speed 2.
- R7: A valid chirp that ends before the stop point starts the chirp train on the next edge, K first. The train alternates K and J every `CHIRP_TICKS` ticks. It never drives both wires high. At `RESET_TICKS - CHIRP_MARGIN_TICKS` ticks after the reset began, the block returns to SE0.
- R8: On the first tick after release, the block reads the line. If it sent the train and the line shows SE0, it reports speed 3. If the line shows J, it reports speed 2.
- R9: A low- or full-speed port falls back to speed 0 after `DISCONNECT_TICKS` consecutive SE0 ticks. A high-speed port falls back after that many consecutive J ticks. Shorter runs keep the speed.
- R10: Both lines high (SE1) is never taken as an idle level, so it never starts an attach.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse per microsecond; all decisions are taken on it |
| line_dp_i | input | 1 | Decoded level of the D+ wire |
| line_dm_i | input | 1 | Decoded level of the D- wire |
| drv_en_o | output | 1 | Port drives the wires |
| drv_dp_o | output | 1 | Value driven on D+ |
| drv_dm_o | output | 1 | Value driven on D- |
| speed_o | output | 2 | Negotiated speed: 0 none, 1 low, 2 full, 3 high |

## Verification
A wrong state or a wrong counter value in this block shows up at the ports as timing errors, and it shows up within one tick of the mistake. Examples are a drive-enable that starts a tick early or late, a reset that is one tick off `RESET_TICKS`, and a chirp phase that flips at the wrong tick. A wrong class or a lost chirp-train flag stays hidden until the single sampling tick after release. It then appears as the wrong speed code. The bench therefore counts ticks from the reset start and checks the drive values at the exact boundary ticks. It also checks the speed code on the sampling tick in every class and outcome.

// File: rtl/usbn_pkg.sv
package usbn_pkg;

   // Decoded line level, packed as {dp, dm}
   localparam logic [1:0] LN_SE0 = 2'b00;
   localparam logic [1:0] LN_K   = 2'b01;
   localparam logic [1:0] LN_J   = 2'b10;
   localparam logic [1:0] LN_SE1 = 2'b11;

   typedef enum logic [1:0] {
      SPD_NONE = 2'd0,
      SPD_LOW  = 2'd1,
      SPD_FULL = 2'd2,
      SPD_HIGH = 2'd3
   } port_speed_e;

   typedef enum logic [2:0] {
      ST_DETACHED,
      ST_DEBOUNCE,
      ST_WAIT_K,
      ST_DEV_K,
      ST_TRAIN,
      ST_HOLD,
      ST_SAMPLE,
      ST_ATTACHED
   } port_state_e;

endpackage

// File: rtl/usbn_tick_counter.sv
module usbn_tick_counter #(
   parameter int unsigned LIMIT = 16,
   localparam int unsigned W = $clog2(LIMIT + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         inc_i,
   output logic [W-1:0] cnt_o
);

   localparam logic [W-1:0] TOP = W'(LIMIT);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("usbn_tick_counter: LIMIT must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt_o <= '0;
      else if (clr_i)                 cnt_o <= '0;
      else if (inc_i && cnt_o != TOP) cnt_o <= cnt_o + 1'b1;
   end

   a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_o <= TOP);

endmodule

// File: rtl/usbn_chirp_train.sv
module usbn_chirp_train #(
   parameter int unsigned CHIRP_TICKS = 50,
   localparam int unsigned CW = $clog2(CHIRP_TICKS)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic run_i,
   output logic drv_dp_o,
   output logic drv_dm_o
);

   localparam logic [CW-1:0] LAST = CW'(CHIRP_TICKS - 1);

   generate
      if (CHIRP_TICKS < 2) begin : g_bad_chirp
         $error("usbn_chirp_train: CHIRP_TICKS must be at least 2");
      end
   endgenerate

   logic [CW-1:0] phase_cnt;
   logic          in_j;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_cnt <= '0;
         in_j      <= 1'b0;
      end else if (!run_i) begin
         phase_cnt <= '0;
         in_j      <= 1'b0;
      end else if (tick_i) begin
         if (phase_cnt == LAST) begin
            phase_cnt <= '0;
            in_j      <= ~in_j;
         end else begin
            phase_cnt <= phase_cnt + 1'b1;
         end
      end
   end

   assign drv_dp_o = run_i & in_j;
   assign drv_dm_o = run_i & ~in_j;

   a_r7_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
      phase_cnt <= LAST);

   a_r7_phase_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && $past(run_i) && phase_cnt != '0) |-> $stable(in_j));

endmodule

// File: rtl/usbn_port_negotiator.sv
module usbn_port_negotiator
   import usbn_pkg::*;
#(
   parameter int unsigned DEBOUNCE_TICKS     = 100,
   parameter int unsigned RESET_TICKS        = 10000,
   parameter int unsigned CHIRP_MIN_TICKS    = 3,
   parameter int unsigned CHIRP_TICKS        = 50,
   parameter int unsigned CHIRP_MARGIN_TICKS = 500,
   parameter int unsigned DISCONNECT_TICKS   = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_i,
   input  logic       line_dp_i,
   input  logic       line_dm_i,
   output logic       drv_en_o,
   output logic       drv_dp_o,
   output logic       drv_dm_o,
   output logic [1:0] speed_o
);

   localparam int unsigned AUX_A   = (DEBOUNCE_TICKS > DISCONNECT_TICKS) ?
                                     DEBOUNCE_TICKS : DISCONNECT_TICKS;
   localparam int unsigned AUX_MAX = (AUX_A > CHIRP_MIN_TICKS) ? AUX_A : CHIRP_MIN_TICKS;
   localparam int unsigned AUX_W   = $clog2(AUX_MAX + 1);
   localparam int unsigned RC_W    = $clog2(RESET_TICKS + 1);
   localparam int unsigned STOP_AT = RESET_TICKS - CHIRP_MARGIN_TICKS;

   generate
      if (DEBOUNCE_TICKS < 2) begin : g_bad_debounce
         $error("usbn_port_negotiator: DEBOUNCE_TICKS must be at least 2");
      end
      if (DISCONNECT_TICKS < 1) begin : g_bad_disc
         $error("usbn_port_negotiator: DISCONNECT_TICKS must be at least 1");
      end
      if (CHIRP_MIN_TICKS < 1) begin : g_bad_min
         $error("usbn_port_negotiator: CHIRP_MIN_TICKS must be at least 1");
      end
      if (CHIRP_MARGIN_TICKS >= RESET_TICKS) begin : g_bad_margin
         $error("usbn_port_negotiator: margin must be shorter than the reset");
      end
   endgenerate

   logic [1:0]       line;
   port_state_e      st_q, st_d;
   port_speed_e      cls_q, cls_d, spd_q, spd_d;
   logic             trained_q, trained_d;
   logic             aux_clr, aux_inc, rc_clr, rc_inc;
   logic [AUX_W-1:0] aux_cnt;
   logic [RC_W-1:0]  rc_cnt;
   logic             in_reset, rc_last, idle_ok, drop;
   logic             train_dp, train_dm;

   assign line = {line_dp_i, line_dm_i};

   usbn_tick_counter #(.LIMIT(AUX_MAX)) i_aux_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (aux_clr),
      .inc_i (aux_inc),
      .cnt_o (aux_cnt)
   );

   usbn_tick_counter #(.LIMIT(RESET_TICKS)) i_reset_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (rc_clr),
      .inc_i (rc_inc),
      .cnt_o (rc_cnt)
   );

   usbn_chirp_train #(.CHIRP_TICKS(CHIRP_TICKS)) i_chirp (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick_i),
      .run_i    (st_q == ST_TRAIN),
      .drv_dp_o (train_dp),
      .drv_dm_o (train_dm)
   );

   assign in_reset = (st_q == ST_WAIT_K) || (st_q == ST_DEV_K) ||
                     (st_q == ST_TRAIN)  || (st_q == ST_HOLD);
   assign rc_last  = tick_i && (int'(rc_cnt) + 1 == int'(RESET_TICKS));
   assign idle_ok  = (cls_q == SPD_LOW) ? (line == LN_K) : (line == LN_J);
   assign drop     = (spd_q == SPD_HIGH) ? (line == LN_J) : (line == LN_SE0);

   always_comb begin
      st_d      = st_q;
      cls_d     = cls_q;
      spd_d     = spd_q;
      trained_d = trained_q;
      aux_clr   = 1'b0;
      aux_inc   = 1'b0;
      rc_clr    = 1'b0;
      rc_inc    = in_reset && tick_i;
      case (st_q)
         ST_DETACHED: begin
            spd_d     = SPD_NONE;
            trained_d = 1'b0;
            if (tick_i && (line == LN_J || line == LN_K)) begin
               aux_inc = 1'b1;
               cls_d   = (line == LN_J) ? SPD_FULL : SPD_LOW;
               st_d    = ST_DEBOUNCE;
            end
         end
         ST_DEBOUNCE: if (tick_i) begin
            if (!idle_ok) begin
               st_d    = ST_DETACHED;
               aux_clr = 1'b1;
            end else if (int'(aux_cnt) + 1 == int'(DEBOUNCE_TICKS)) begin
               st_d    = (cls_q == SPD_LOW) ? ST_HOLD : ST_WAIT_K;
               aux_clr = 1'b1;
               rc_clr  = 1'b1;
            end else begin
               aux_inc = 1'b1;
            end
         end
         ST_WAIT_K: if (tick_i) begin
            if (rc_last) begin
               st_d    = ST_SAMPLE;
               aux_clr = 1'b1;
            end else if (line == LN_K) begin
               st_d    = ST_DEV_K;
               aux_inc = 1'b1;
            end
         end
         ST_DEV_K: if (tick_i) begin
            if (rc_last) begin
               st_d    = ST_SAMPLE;
               aux_clr = 1'b1;
            end else if (line == LN_K) begin
               aux_inc = 1'b1;
            end else begin
               aux_clr = 1'b1;
               st_d    = ST_WAIT_K;
               if (line == LN_SE0 && int'(aux_cnt) >= int'(CHIRP_MIN_TICKS)) begin
                  if (int'(rc_cnt) + 1 < int'(STOP_AT)) begin
                     st_d      = ST_TRAIN;
                     trained_d = 1'b1;
                  end else begin
                     st_d = ST_HOLD;
                  end
               end
            end
         end
         ST_TRAIN: if (tick_i) begin
            if (rc_last)                                   st_d = ST_SAMPLE;
            else if (int'(rc_cnt) + 1 >= int'(STOP_AT))    st_d = ST_HOLD;
         end
         ST_HOLD: if (rc_last) begin
            st_d = ST_SAMPLE;
         end
         ST_SAMPLE: if (tick_i) begin
            aux_clr = 1'b1;
            st_d    = ST_ATTACHED;
            if (cls_q == SPD_LOW)                      spd_d = SPD_LOW;
            else if (trained_q && line == LN_SE0)      spd_d = SPD_HIGH;
            else                                       spd_d = SPD_FULL;
         end
         ST_ATTACHED: if (tick_i) begin
            if (!drop) begin
               aux_clr = 1'b1;
            end else if (int'(aux_cnt) + 1 == int'(DISCONNECT_TICKS)) begin
               aux_clr = 1'b1;
               spd_d   = SPD_NONE;
               st_d    = ST_DETACHED;
            end else begin
               aux_inc = 1'b1;
            end
         end
         default: st_d = ST_DETACHED;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_DETACHED;
         cls_q     <= SPD_NONE;
         spd_q     <= SPD_NONE;
         trained_q <= 1'b0;
      end else begin
         st_q      <= st_d;
         cls_q     <= cls_d;
         spd_q     <= spd_d;
         trained_q <= trained_d;
      end
   end

   assign drv_en_o = in_reset;
   assign drv_dp_o = train_dp;
   assign drv_dm_o = train_dm;
   assign speed_o  = spd_q;

   a_r7_no_se1_drive: assert property (@(posedge clk) disable iff (!rst_n)
      drv_en_o |-> !(drv_dp_o && drv_dm_o));

   a_r4_quiet_when_attached: assert property (@(posedge clk) disable iff (!rst_n)
      (spd_q != SPD_NONE) |-> !drv_en_o);

   a_r7_train_opens_with_k: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_q == ST_TRAIN) |-> (drv_dm_o && !drv_dp_o));

   a_r3_low_never_chirps: assert property (@(posedge clk) disable iff (!rst_n)
      (cls_q == SPD_LOW && drv_en_o) |-> !(drv_dp_o || drv_dm_o));

   a_r8_high_needs_train: assert property (@(posedge clk) disable iff (!rst_n)
      (spd_q == SPD_HIGH) |-> trained_q);

   a_r4_reset_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      in_reset |-> (int'(rc_cnt) < int'(RESET_TICKS)));

endmodule

// File: tb/test_usbn_port_negotiator.sv
module test_usbn_port_negotiator;

   localparam int DEB  = 8;
   localparam int RST  = 200;
   localparam int MINK = 3;
   localparam int CHP  = 5;
   localparam int MRG  = 30;
   localparam int DISC = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       dp = 1'b0;
   logic       dm = 1'b0;
   logic       en_o, dp_o, dm_o;
   logic [1:0] spd_o;

   int checks = 0;
   int failures = 0;
   int tk = 0;
   int tk0 = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   usbn_port_negotiator #(
      .DEBOUNCE_TICKS(DEB), .RESET_TICKS(RST), .CHIRP_MIN_TICKS(MINK),
      .CHIRP_TICKS(CHP), .CHIRP_MARGIN_TICKS(MRG), .DISCONNECT_TICKS(DISC)
   ) i_usbn_port_negotiator (
      .clk(clk), .rst_n(rst_n), .tick_i(tick),
      .line_dp_i(dp), .line_dm_i(dm),
      .drv_en_o(en_o), .drv_dp_o(dp_o), .drv_dm_o(dm_o), .speed_o(spd_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at tick %0d", req, act, exp, tk);
      end
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) tick = 1'b1;
         @(negedge clk) tick = 1'b0;
         tk++;
      end
   endtask

   task automatic set_line(input logic p, input logic m);
      dp = p;
      dm = m;
   endtask

   function automatic int drive3();
      return {29'd0, en_o, dp_o, dm_o};
   endfunction

   task automatic until_rel(input int target);
      while (tk - tk0 < target) ticks(1);
   endtask

   // Attach with a given idle level, accept it and mark the reset start
   task automatic attach(input logic p, input logic m);
      set_line(p, m);
      ticks(DEB);
      tk0 = tk;
   endtask

   task automatic t_reset_state();
      chk("R1 drive after reset", drive3(), 0);
      chk("R1 speed after reset", spd_o, 0);
   endtask

   task automatic t_se1_ignored();
      set_line(1, 1);
      ticks(30);
      chk("R10 SE1 does not start attach", drive3(), 0);
      set_line(0, 0);
      ticks(2);
   endtask

   // Full-capable device that never chirps; debounce restart included
   task automatic t_full_no_chirp();
      set_line(1, 0);
      ticks(4);
      set_line(0, 0);
      ticks(1);
      set_line(1, 0);
      ticks(DEB - 1);
      chk("R2 no drive before debounce done", drive3(), 0);
      ticks(1);
      tk0 = tk;
      chk("R2 SE0 driven after debounce", drive3(), 3'b100);
      set_line(0, 0);
      ticks(3);
      set_line(0, 1);
      ticks(MINK - 1);
      set_line(0, 0);
      ticks(1);
      chk("R5 short K ignored, still SE0", drive3(), 3'b100);
      until_rel(RST - 1);
      chk("R4 still driving at last reset tick", drive3(), 3'b100);
      ticks(1);
      chk("R4 released after reset", drive3(), 0);
      chk("R4 no speed before sampling", spd_o, 0);
      set_line(1, 0);
      ticks(1);
      chk("R6 no chirp gives full", spd_o, 2);
      set_line(0, 0);
      ticks(DISC - 1);
      chk("R9 short SE0 keeps full", spd_o, 2);
      ticks(1);
      chk("R9 SE0 disconnect", spd_o, 0);
   endtask

   // Device chirps, switches, and ends in high speed
   task automatic t_high_speed();
      attach(1, 0);
      set_line(0, 0);
      ticks(2);
      set_line(0, 1);
      ticks(4);
      set_line(0, 0);
      ticks(1);
      chk("R7 train starts with K", drive3(), 3'b101);
      ticks(CHP - 1);
      chk("R7 K held for full period", drive3(), 3'b101);
      ticks(1);
      chk("R7 J follows K", drive3(), 3'b110);
      ticks(CHP);
      chk("R7 K follows J", drive3(), 3'b101);
      until_rel(RST - MRG - 1);
      chk("R7 chirping just before stop", int'(en_o && (dp_o ^ dm_o)), 1);
      ticks(1);
      chk("R7 SE0 at stop point", drive3(), 3'b100);
      until_rel(RST);
      chk("R4 released after trained reset", drive3(), 0);
      ticks(1);
      chk("R8 SE0 after train gives high", spd_o, 3);
      ticks(10);
      chk("R9 SE0 idle keeps high", spd_o, 3);
      set_line(1, 0);
      ticks(DISC - 1);
      chk("R9 short J keeps high", spd_o, 3);
      ticks(1);
      chk("R9 J disconnect from high", spd_o, 0);
      set_line(0, 0);
      ticks(2);
   endtask

   // Minimum-length chirp answered, but device stays full speed
   task automatic t_train_then_full();
      attach(1, 0);
      set_line(0, 1);
      ticks(MINK);
      set_line(0, 0);
      ticks(1);
      chk("R5 minimum K accepted", drive3(), 3'b101);
      until_rel(RST);
      set_line(1, 0);
      ticks(1);
      chk("R8 J after train gives full", spd_o, 2);
      set_line(0, 0);
      ticks(DISC);
      chk("R9 disconnect after full", spd_o, 0);
   endtask

   task automatic t_low_speed();
      attach(0, 1);
      chk("R3 low attach starts SE0", drive3(), 3'b100);
      ticks(6);
      chk("R3 K during low reset not answered", drive3(), 3'b100);
      set_line(0, 0);
      ticks(1);
      chk("R3 no chirp after low K ends", drive3(), 3'b100);
      until_rel(RST);
      chk("R4 low reset released", drive3(), 0);
      set_line(0, 1);
      ticks(1);
      chk("R3 low speed reported", spd_o, 1);
      set_line(0, 0);
      ticks(DISC);
      chk("R9 low disconnect", spd_o, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_se1_ignored();
      t_full_no_chirp();
      t_high_speed();
      t_train_then_full();
      t_low_speed();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule